// File: doc/BRIEF.md
# Two-Phase Multiplexed Address Nibble Memory Controller

The controller accepts a flat 22-bit cell address from a host, together with a read or write request and a 4-bit write nibble, over a valid/ready handshake. The memory it drives has only 11 address pins, so the address is sent in two steps. First the upper half goes out as the row and is marked by a row strobe. Then the lower half goes out as the column and is marked by a column strobe. Each access moves one nibble, with one bit held in each of four identical arrays that share the row and column selection.

A write-enable pin and an output-enable pin choose the direction during the data phase. They are never active together. After the data phase both strobes drop for one precharge cycle, and then the controller goes back to idle. A read returns its nibble with a one-cycle valid pulse in that precharge cycle.

For simulation, a behavioural storage model sits behind the pins. It keeps only the low `MEM_ROW_W` row bits and the low `MEM_COL_W` column bits, so the model can be made smaller than a full 2048 x 2048 array.

Top module: `mux_addr_mem_ctrl`

## Requirements
- R1: While reset is active and after its release, the controller is idle. `req_ready_o` is 1. `row_stb_o`, `col_stb_o`, `we_o`, `oe_o` and `rsp_valid_o` are all 0.
- R2: `req_ready_o` is 1 only in idle. After a request is accepted, it stays 0 for exactly four cycles (row, column, data, precharge) and is 1 again in the fifth.
- R3: In the first cycle after acceptance, `dev_addr_o` carries address bits [21:11], `row_stb_o` is 1 and `col_stb_o` is 0.
- R4: In the second cycle, `dev_addr_o` carries address bits [10:0] and both strobes are 1.
- R5: In the third cycle (the data phase), both strobes stay 1. A write drives `we_o`=1, `oe_o`=0 and puts the request nibble on `dev_wdata_o`. A read drives `oe_o`=1 and `we_o`=0.
- R6: In the fourth cycle (precharge), both strobes, `we_o` and `oe_o` are 0. The controller is idle in the next cycle.
- R7: `we_o` and `oe_o` are never 1 together, and both are 0 outside the data phase.
- R8: A read raises `rsp_valid_o` for exactly one cycle, in its precharge cycle. `rsp_rdata_o` then holds the nibble most recently written to that cell. A write never raises `rsp_valid_o`.
- R9: The four data bits are stored independently. A nibble with any single bit set reads back unchanged, and the other bits of that cell stay 0.
- R10: The storage model indexes each cell by row bits [MEM_ROW_W-1:0] and column bits [MEM_COL_W-1:0]. Two addresses that agree on those bits refer to the same cell.
- R11: A cell that has not been written since reset reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller idle and able to accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 22 | Flat cell address: row in [21:11], column in [10:0] |
| req_wdata_i | input | 4 | Write nibble |
| rsp_valid_o | output | 1 | One-cycle pulse that marks read data |
| rsp_rdata_o | output | 4 | Read nibble |
| dev_addr_o | output | 11 | Multiplexed device address pins |
| row_stb_o | output | 1 | Row strobe, active high |
| col_stb_o | output | 1 | Column strobe, active high |
| we_o | output | 1 | Device write enable |
| oe_o | output | 1 | Device output enable |
| dev_wdata_o | output | 4 | Nibble driven toward the device |

## Verification
The bench keeps the full 11-bit row and column widths, so every pin phase carries a real 11-bit half of the address. It reduces the storage model to `MEM_ROW_W`=3 and `MEM_COL_W`=3, which gives 64 cells per array. With that size, the bench can easily pick addresses that differ only in bits above the kept ones (bit 21 of the row half, bit 10 of the column half). Such addresses must alias to the same cell, and the bench uses this to check the indexing. The small array also lets the bench read never-written cells, write single-bit patterns to show the four lanes are independent, and run back-to-back read/write sequences against a model of the same size.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_COL  = 3'd2,
    ST_DATA = 3'd3,
    ST_PRE  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/mrc_addr_split.sv
module mrc_addr_split #(
  parameter int ROW_W = 11,
  parameter int COL_W = 11
) (
  input  logic [ROW_W+COL_W-1:0] flat_addr_i,
  output logic [ROW_W-1:0]       row_o,
  output logic [COL_W-1:0]       col_o
);
  // Row is the upper half, column the lower half.
  assign row_o = flat_addr_i[ROW_W+COL_W-1:COL_W];
  assign col_o = flat_addr_i[COL_W-1:0];
endmodule

// File: rtl/mrc_seq.sv
module mrc_seq
  import mrc_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int COL_W = 11,
  parameter int NIB_W = 4,
  localparam int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic [NIB_W-1:0] req_wdata_i,
  output logic             req_ready_o,
  output logic             rsp_valid_o,
  output logic [NIB_W-1:0] rsp_rdata_o,
  output logic [PIN_W-1:0] dev_addr_o,
  output logic             row_stb_o,
  output logic             col_stb_o,
  output logic             we_o,
  output logic             oe_o,
  output logic [NIB_W-1:0] dev_wdata_o,
  input  logic [NIB_W-1:0] dev_rdata_i
);
  seq_state_e state_q, state_d;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [NIB_W-1:0] wdata_q, rdata_q;
  logic             wr_q, rsp_valid_q;
  logic             accept;

  assign accept = (state_q == ST_IDLE) && req_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) state_d = ST_ROW;
      ST_ROW:  state_d = ST_COL;
      ST_COL:  state_d = ST_DATA;
      ST_DATA: state_d = ST_PRE;
      ST_PRE:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      row_q       <= '0;
      col_q       <= '0;
      wdata_q     <= '0;
      wr_q        <= 1'b0;
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= (state_q == ST_DATA) && !wr_q;
      if (accept) begin
        row_q   <= req_row_i;
        col_q   <= req_col_i;
        wdata_q <= req_wdata_i;
        wr_q    <= req_write_i;
      end
      if ((state_q == ST_DATA) && !wr_q) rdata_q <= dev_rdata_i;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_ROW:           dev_addr_o = PIN_W'(row_q);
      ST_COL, ST_DATA:  dev_addr_o = PIN_W'(col_q);
      default:          dev_addr_o = '0;
    endcase
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign row_stb_o   = (state_q == ST_ROW) || (state_q == ST_COL) || (state_q == ST_DATA);
  assign col_stb_o   = (state_q == ST_COL) || (state_q == ST_DATA);
  assign we_o        = (state_q == ST_DATA) && wr_q;
  assign oe_o        = (state_q == ST_DATA) && !wr_q;
  assign dev_wdata_o = we_o ? wdata_q : '0;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rdata_q;
endmodule

// File: rtl/mrc_cell_array.sv
module mrc_cell_array #(
  parameter int NIB_W     = 4,
  parameter int MEM_ROW_W = 4,
  parameter int MEM_COL_W = 4,
  localparam int IDX_W    = MEM_ROW_W + MEM_COL_W,
  localparam int DEPTH    = 1 << IDX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [MEM_ROW_W-1:0] row_pins_i,
  input  logic [MEM_COL_W-1:0] col_pins_i,
  input  logic                 row_stb_i,
  input  logic                 col_stb_i,
  input  logic                 we_i,
  input  logic                 oe_i,
  input  logic [NIB_W-1:0]     wdata_i,
  output logic [NIB_W-1:0]     rdata_o
);
  logic                 row_stb_d, col_stb_d;
  logic [MEM_ROW_W-1:0] row_lat;
  logic [MEM_COL_W-1:0] col_lat;
  logic [IDX_W-1:0]     idx;

  // Latch each half on the rising edge of its strobe.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_stb_d <= 1'b0;
      col_stb_d <= 1'b0;
      row_lat   <= '0;
      col_lat   <= '0;
    end else begin
      row_stb_d <= row_stb_i;
      col_stb_d <= col_stb_i;
      if (row_stb_i && !row_stb_d) row_lat <= row_pins_i;
      if (col_stb_i && !col_stb_d) col_lat <= col_pins_i;
    end
  end

  assign idx = {row_lat, col_lat};

  for (genvar g = 0; g < NIB_W; g++) begin : g_lane
    logic [DEPTH-1:0] bits_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   bits_q      <= '0;
      else if (we_i) bits_q[idx] <= wdata_i[g];
    end
    assign rdata_o[g] = oe_i ? bits_q[idx] : 1'b0;
  end
endmodule

// File: rtl/mux_addr_mem_ctrl.sv
module mux_addr_mem_ctrl #(
  parameter int ROW_W     = 11,
  parameter int COL_W     = 11,
  parameter int NIB_W     = 4,
  parameter int MEM_ROW_W = 4,
  parameter int MEM_COL_W = 4,
  localparam int PIN_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic                   req_write_i,
  input  logic [ROW_W+COL_W-1:0] req_addr_i,
  input  logic [NIB_W-1:0]       req_wdata_i,
  output logic                   rsp_valid_o,
  output logic [NIB_W-1:0]       rsp_rdata_o,
  output logic [PIN_W-1:0]       dev_addr_o,
  output logic                   row_stb_o,
  output logic                   col_stb_o,
  output logic                   we_o,
  output logic                   oe_o,
  output logic [NIB_W-1:0]       dev_wdata_o
);
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic [NIB_W-1:0] dev_rdata;

  mrc_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
    .flat_addr_i (req_addr_i),
    .row_o       (req_row),
    .col_o       (req_col)
  );

  mrc_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .NIB_W(NIB_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_row_i   (req_row),
    .req_col_i   (req_col),
    .req_wdata_i (req_wdata_i),
    .req_ready_o (req_ready_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .dev_addr_o  (dev_addr_o),
    .row_stb_o   (row_stb_o),
    .col_stb_o   (col_stb_o),
    .we_o        (we_o),
    .oe_o        (oe_o),
    .dev_wdata_o (dev_wdata_o),
    .dev_rdata_i (dev_rdata)
  );

  mrc_cell_array #(.NIB_W(NIB_W), .MEM_ROW_W(MEM_ROW_W), .MEM_COL_W(MEM_COL_W)) u_cells (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .row_pins_i (dev_addr_o[MEM_ROW_W-1:0]),
    .col_pins_i (dev_addr_o[MEM_COL_W-1:0]),
    .row_stb_i  (row_stb_o),
    .col_stb_i  (col_stb_o),
    .we_i       (we_o),
    .oe_i       (oe_o),
    .wdata_i    (dev_wdata_o),
    .rdata_o    (dev_rdata)
  );
endmodule

// File: rtl/mrc_checker.sv
module mrc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic row_stb_o,
  input logic col_stb_o,
  input logic we_o,
  input logic oe_o,
  input logic rsp_valid_o
);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !row_stb_o && !col_stb_o && !we_o && !oe_o);

  assert_row_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(row_stb_o) |-> !col_stb_o && $past(req_ready_o));

  assert_col_after_row_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(col_stb_o) |-> row_stb_o && $past(row_stb_o));

  assert_data_strobed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o || oe_o) |-> row_stb_o && col_stb_o && $past(col_stb_o));

  assert_precharge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(row_stb_o) |-> !col_stb_o ##1 req_ready_o);

  assert_no_we_oe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_o && oe_o));

  assert_rsp_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(oe_o) && !row_stb_o ##1 !rsp_valid_o);
endmodule

bind mux_addr_mem_ctrl mrc_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .row_stb_o   (row_stb_o),
  .col_stb_o   (col_stb_o),
  .we_o        (we_o),
  .oe_o        (oe_o),
  .rsp_valid_o (rsp_valid_o)
);

// File: tb/mux_addr_mem_ctrl_tb.sv
module mux_addr_mem_ctrl_tb;
  localparam int MR = 3;
  localparam int MC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, row_stb, col_stb, we, oe;
  logic [3:0]  rsp_rdata, dev_wdata;
  logic [10:0] dev_addr;

  int n_checks = 0;
  int n_fails  = 0;
  logic [3:0] exp_q[$];
  logic [3:0] ref_mem [0:63];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mux_addr_mem_ctrl #(.MEM_ROW_W(MR), .MEM_COL_W(MC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .dev_addr_o(dev_addr), .row_stb_o(row_stb), .col_stb_o(col_stb),
    .we_o(we), .oe_o(oe), .dev_wdata_o(dev_wdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int cell_idx(input logic [21:0] a);
    return int'({a[11+MR-1:11], a[MC-1:0]});
  endfunction

  // Driver: called at a negedge; walks the pin phases of one access.
  task automatic do_req(input bit wr, input logic [21:0] a, input logic [3:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) ref_mem[cell_idx(a)] = d;
    else    exp_q.push_back(ref_mem[cell_idx(a)]);
    @(negedge clk);
    req_valid = 1'b0;
    chk(dev_addr == a[21:11] && row_stb && !col_stb, "R3 row phase", {dev_addr, row_stb, col_stb}, {a[21:11], 2'b10});
    chk(!req_ready, "R2 busy in row phase", req_ready, 0);
    @(negedge clk);
    chk(dev_addr == a[10:0] && row_stb && col_stb, "R4 column phase", {dev_addr, row_stb, col_stb}, {a[10:0], 2'b11});
    chk(!we && !oe, "R7 enables low before data", {we, oe}, 0);
    @(negedge clk);
    if (wr) chk(row_stb && col_stb && we && !oe && dev_wdata == d, "R5 write data phase",
                {row_stb, col_stb, we, oe, dev_wdata}, {4'b1110, d});
    else    chk(row_stb && col_stb && !we && oe, "R5 read data phase",
                {row_stb, col_stb, we, oe}, 4'b1101);
    @(negedge clk);
    chk(!row_stb && !col_stb && !we && !oe && !req_ready, "R6 precharge",
        {row_stb, col_stb, we, oe, req_ready}, 0);
    if (wr) chk(!rsp_valid, "R8 no response on write", rsp_valid, 0);
    @(negedge clk);
    chk(req_ready, "R2 R6 idle after precharge", req_ready, 1);
  endtask

  // Monitor: compares each read response with the scoreboard head.
  logic rsp_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected response", rsp_rdata, 0);
        else begin
          automatic logic [3:0] e = exp_q.pop_front();
          chk(rsp_rdata == e, "R8 R9 R10 R11 read data", rsp_rdata, e);
        end
        if (rsp_prev) chk(1'b0, "R8 response longer than one cycle", 2, 1);
      end
      rsp_prev <= rsp_valid;
    end
  end

  initial begin
    #1000000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && !row_stb && !col_stb && !we && !oe && !rsp_valid, "R1 reset state",
        {req_ready, row_stb, col_stb, we, oe, rsp_valid}, 6'b100000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !row_stb && !col_stb && !we && !oe, "R1 idle after reset",
        {req_ready, row_stb, col_stb, we, oe}, 5'b10000);

    do_req(1'b0, {11'h5A5, 11'h2C3}, 4'h0);        // R11 unwritten cell
    do_req(1'b1, {11'h123, 11'h456}, 4'hA);
    do_req(1'b1, {11'h7FE, 11'h001}, 4'h5);
    do_req(1'b0, {11'h123, 11'h456}, 4'h0);
    do_req(1'b0, {11'h7FE, 11'h001}, 4'h0);
    // R9 single-bit lanes into four cells
    for (int b = 0; b < 4; b++) do_req(1'b1, {11'(b), 11'h007}, 4'(1 << b));
    for (int b = 0; b < 4; b++) do_req(1'b0, {11'(b), 11'h007}, 4'h0);
    // R10 aliasing: flip row bit 21 and column bit 10
    do_req(1'b1, {11'h002, 11'h003}, 4'hF);
    do_req(1'b0, {11'h402, 11'h003}, 4'h0);
    do_req(1'b0, {11'h002, 11'h403}, 4'h0);
    do_req(1'b1, {11'h40A, 11'h7FB}, 4'h6);
    do_req(1'b0, {11'h002, 11'h003}, 4'h0);
    do_req(1'b1, {11'h002, 11'h003}, 4'h0);
    do_req(1'b0, {11'h002, 11'h003}, 4'h0);
    do_req(1'b0, {11'h3C4, 11'h0F5}, 4'h0);        // R11 another unwritten cell

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all reads answered", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule